// File: doc/BRIEF.md
# Option Byte Loader with Complement Check

This block runs once after every system reset. It reads a small non-volatile information area of three 32-bit words through a synchronous read port, one word at a time. Each word carries two configuration bytes, and each byte is stored next to its bitwise inverse. The loader checks every byte against its inverse. A byte that fails the check is replaced by 0xFF and raises a sticky error flag. A pair in which both bytes read as 0xFF is treated as erased, so it loads 0xFF and raises no error. When all words are checked, the loader commits the results into an option register and a write-protect register, decodes the read-protection level, and gives a single done pulse.

The information area is modelled as a parameterised array whose contents enter the block on a flat input vector. The array is read with one cycle of latency. Until the commit, every output holds a safe value: all write protection active and read protection at the middle level.

Top module: `optload`

## Requirements
- R1: Loading starts by itself when reset is released. `loadDone` is high for exactly one cycle, visible after the 7th rising clock edge on which `rstN` is high, and it does not rise again until the next reset.
- R2: Information word k occupies `infoContent[32k+31:32k]`. Within a word, bits [7:0] hold a value and bits [15:8] its inverse, and bits [23:16] hold a value and bits [31:24] its inverse.
- R3: Word 0 bits [7:0] load into `optReg[7:0]` (the read-protection byte), and word 0 bits [23:16] load into `optReg[15:8]` (user configuration). Word 1 bits [7:0] load into `optReg[23:16]`, and word 1 bits [23:16] load into `optReg[31:24]` (user data). Word 2 bits [7:0] load into `wrpReg[7:0]` (pages 0 to 15), and word 2 bits [23:16] load into `wrpReg[15:8]` (pages 16 to 31). In `wrpReg`, 0 means protected.
- R4: When a value byte is not the bitwise inverse of its partner byte, that value loads as 0xFF and `optErr` is 1 after the commit.
- R5: When both bytes of a pair are 0xFF, the value loads as 0xFF and the pair raises no error.
- R6: `rdpLevel` is 0 when `optReg[7:0]` is 0xAA, 2 when it is 0xCC, and 1 for any other value.
- R7: From reset until the commit, `optReg` is 0xFFFFFFFF, `wrpReg` is all zeros, `rdpLevel` is 1 and `optErr` is 0.
- R8: `optErr` is the OR of the errors of all six pairs. It stays set until the next reset, and a new reset with a clean image clears it.
- R9: After the commit, `optReg`, `wrpReg`, `rdpLevel` and `optErr` do not change until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| infoContent | input | 32*WORDS | Contents of the information area, with word k at bits [32k+31:32k] |
| optReg | output | 32 | Loaded option register |
| wrpReg | output | 8*(2*WORDS-4) | Loaded write-protect register (0 = protected) |
| rdpLevel | output | 2 | Decoded read-protection level (0, 1 or 2) |
| optErr | output | 1 | Sticky option-error flag |
| loadDone | output | 1 | One-cycle pulse when the loaded values are committed |

## Verification
Every loaded value, the error flag and the decoded level become visible together with `loadDone`, after the 7th rising edge that follows reset release. Nothing is visible earlier, because the read and capture pairs for the three words take six edges and the commit takes one more. The bench releases reset on a falling edge and then samples on each following falling edge. It expects the defaults on edges 1 to 6, the committed values and the done pulse at edge 7, and the same values with done low at edge 8. Expected bytes and error flags come from a bench model of the pair rule applied to the image that the bench wrote.

// File: rtl/optload_pkg.sv
package optload_pkg;

  typedef enum logic [1:0] {
    RDP_OPEN   = 2'd0,
    RDP_LOCKED = 2'd1,
    RDP_SEALED = 2'd2
  } rdp_level_e;

  localparam logic [7:0] RDP_OPEN_CODE   = 8'hAA;
  localparam logic [7:0] RDP_SEALED_CODE = 8'hCC;
  localparam logic [7:0] ERASED_BYTE     = 8'hFF;

  // Strobes from control to datapath; idx is wide enough for any word index
  typedef struct packed {
    logic       rdEn;
    logic       capture;
    logic       commit;
    logic [7:0] idx;
  } load_strobe_t;

endpackage

// File: rtl/optload_infomem.sv
module optload_infomem #(
  parameter int WORDS  = 3,
  parameter int ADDR_W = 2
) (
  input  logic                  clk,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     rdAddr,
  input  logic [32*WORDS-1:0]   content,
  output logic [31:0]           rdData
);

  logic [31:0] wordArr [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign wordArr[w] = content[32*w +: 32];
  end

  always_ff @(posedge clk) begin
    if (rdEn) rdData <= wordArr[rdAddr];
  end

endmodule

// File: rtl/optload_ctrl.sv
module optload_ctrl
  import optload_pkg::*;
#(
  parameter int WORDS = 3
) (
  input  logic         clk,
  input  logic         rstN,
  output load_strobe_t strb
);

  typedef enum logic [1:0] {ST_READ, ST_CAPT, ST_COMMIT, ST_HALT} state_e;

  localparam logic [7:0] LAST_IDX = 8'(WORDS - 1);

  state_e     state;
  logic [7:0] wordIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_READ;
      wordIdx <= '0;
    end else begin
      unique case (state)
        ST_READ: state <= ST_CAPT;
        ST_CAPT: begin
          if (wordIdx == LAST_IDX) begin
            state <= ST_COMMIT;
          end else begin
            wordIdx <= wordIdx + 8'd1;
            state   <= ST_READ;
          end
        end
        ST_COMMIT: state <= ST_HALT;
        default:   state <= ST_HALT;
      endcase
    end
  end

  always_comb begin
    strb.rdEn    = (state == ST_READ);
    strb.capture = (state == ST_CAPT);
    strb.commit  = (state == ST_COMMIT);
    strb.idx     = wordIdx;
  end

endmodule

// File: rtl/optload_datapath.sv
module optload_datapath
  import optload_pkg::*;
#(
  parameter int WORDS = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  load_strobe_t                strb,
  input  logic [31:0]                 memData,
  output logic [31:0]                 optReg,
  output logic [8*(2*WORDS-4)-1:0]    wrpReg,
  output logic [1:0]                  rdpLevel,
  output logic                        optErr,
  output logic                        loadDone
);

  localparam int NUM_BYTES = 2 * WORDS;
  localparam int WRP_BYTES = NUM_BYTES - 4;

  logic [7:0] laneVal [2];
  logic [1:0] laneBad;
  logic [7:0] shByte  [NUM_BYTES];
  logic       errAcc;

  // Pair check on the two lanes of the word being captured
  for (genvar p = 0; p < 2; p++) begin : g_lane
    logic [7:0] val, inv;
    logic       erased;
    assign val          = memData[16*p +: 8];
    assign inv          = memData[16*p + 8 +: 8];
    assign erased       = (val == ERASED_BYTE) && (inv == ERASED_BYTE);
    assign laneBad[p]   = !erased && (val != ~inv);
    assign laneVal[p]   = laneBad[p] ? ERASED_BYTE : val;
  end

  // Shadow bytes, one per pair, filled word by word
  for (genvar w = 0; w < WORDS; w++) begin : g_shw
    for (genvar p = 0; p < 2; p++) begin : g_shp
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          shByte[2*w+p] <= ERASED_BYTE;
        else if (strb.capture && (strb.idx == 8'(w)))
          shByte[2*w+p] <= laneVal[p];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              errAcc <= 1'b0;
    else if (strb.capture)  errAcc <= errAcc | (|laneBad);
  end

  // Committed outputs; safe values until commit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      optReg   <= '1;
      wrpReg   <= '0;
      optErr   <= 1'b0;
      loadDone <= 1'b0;
    end else begin
      loadDone <= strb.commit;
      if (strb.commit) begin
        optReg <= {shByte[3], shByte[2], shByte[1], shByte[0]};
        optErr <= errAcc;
      end
    end
  end

  for (genvar b = 0; b < WRP_BYTES; b++) begin : g_wrp
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            wrpReg[8*b +: 8] <= 8'h00;
      else if (strb.commit) wrpReg[8*b +: 8] <= shByte[4+b];
    end
  end

  always_comb begin
    unique case (optReg[7:0])
      RDP_OPEN_CODE:   rdpLevel = RDP_OPEN;
      RDP_SEALED_CODE: rdpLevel = RDP_SEALED;
      default:         rdpLevel = RDP_LOCKED;
    endcase
  end

endmodule

// File: rtl/optload.sv
module optload
  import optload_pkg::*;
#(
  parameter int WORDS = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [32*WORDS-1:0]         infoContent,
  output logic [31:0]                 optReg,
  output logic [8*(2*WORDS-4)-1:0]    wrpReg,
  output logic [1:0]                  rdpLevel,
  output logic                        optErr,
  output logic                        loadDone
);

  localparam int ADDR_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  load_strobe_t      strb;
  logic [31:0]       memData;
  logic              memRdEn;
  logic [ADDR_W-1:0] memAddr;

  assign memRdEn = strb.rdEn;
  assign memAddr = strb.idx[ADDR_W-1:0];

  optload_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .strb (strb)
  );

  optload_infomem #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_mem (
    .clk     (clk),
    .rdEn    (memRdEn),
    .rdAddr  (memAddr),
    .content (infoContent),
    .rdData  (memData)
  );

  optload_datapath #(.WORDS(WORDS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .memData  (memData),
    .optReg   (optReg),
    .wrpReg   (wrpReg),
    .rdpLevel (rdpLevel),
    .optErr   (optErr),
    .loadDone (loadDone)
  );

endmodule

// File: rtl/optload_chk.sv
module optload_chk #(
  parameter int WORDS  = 3,
  parameter int ADDR_W = 2
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [31:0]              optReg,
  input logic [8*(2*WORDS-4)-1:0] wrpReg,
  input logic [1:0]               rdpLevel,
  input logic                     optErr,
  input logic                     loadDone,
  input logic                     memRdEn,
  input logic [ADDR_W-1:0]        memAddr
);

  logic seenDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         seenDone <= 1'b0;
    else if (loadDone) seenDone <= 1'b1;
  end

  // R1
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> !loadDone);

  // R1
  done_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    seenDone |-> !loadDone);

  // R2
  addr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> (32'(memAddr) < WORDS));

  // R7
  safe_default_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!seenDone && !loadDone) |-> (optReg == '1 && wrpReg == '0 &&
                                  rdpLevel == 2'd1 && !optErr));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    optErr |=> optErr);

  // R9
  hold_after_chk: assert property (@(posedge clk) disable iff (!rstN)
    seenDone |-> ($stable(optReg) && $stable(wrpReg) && $stable(optErr)));

endmodule

bind optload optload_chk #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .optReg   (optReg),
  .wrpReg   (wrpReg),
  .rdpLevel (rdpLevel),
  .optErr   (optErr),
  .loadDone (loadDone),
  .memRdEn  (memRdEn),
  .memAddr  (memAddr)
);

// File: tb/optload_tb.sv
`timescale 1ns/1ps
module optload_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [95:0] infoContent = '1;
  logic [31:0] optReg;
  logic [15:0] wrpReg;
  logic [1:0]  rdpLevel;
  logic        optErr;
  logic        loadDone;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  optload #(.WORDS(3)) u_dut (
    .clk(clk), .rstN(rstN), .infoContent(infoContent),
    .optReg(optReg), .wrpReg(wrpReg), .rdpLevel(rdpLevel),
    .optErr(optErr), .loadDone(loadDone)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pr(input logic [7:0] v);
    return {~v, v};
  endfunction

  // Pair rule from R4/R5
  function automatic logic [7:0] expByte(input logic [15:0] p);
    if (p[7:0] == 8'hFF && p[15:8] == 8'hFF) return 8'hFF;
    if (p[7:0] != ~p[15:8]) return 8'hFF;
    return p[7:0];
  endfunction

  function automatic logic expBad(input logic [15:0] p);
    return !(p[7:0] == 8'hFF && p[15:8] == 8'hFF) && (p[7:0] != ~p[15:8]);
  endfunction

  // Reset, then walk the load and check timing and defaults (R1, R7, R9)
  task automatic runLoad(input logic [95:0] img);
    logic [31:0] optSeen;
    logic [15:0] wrpSeen;
    @(negedge clk);
    rstN = 1'b0;
    infoContent = img;
    @(negedge clk);
    chk("R7 reset optReg", optReg, 32'hFFFF_FFFF);
    chk("R7 reset wrpReg", {16'h0, wrpReg}, 32'h0);
    rstN = 1'b1;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      chk("R1 done low before commit", {31'h0, loadDone}, 32'h0);
    end
    chk("R7 default rdpLevel", {30'h0, rdpLevel}, 32'd1);
    chk("R7 default optErr", {31'h0, optErr}, 32'h0);
    chk("R7 default wrpReg", {16'h0, wrpReg}, 32'h0);
    @(negedge clk);
    chk("R1 done at edge 7", {31'h0, loadDone}, 32'h1);
    optSeen = optReg;
    wrpSeen = wrpReg;
    @(negedge clk);
    chk("R1 done one cycle", {31'h0, loadDone}, 32'h0);
    repeat (3) @(negedge clk);
    chk("R9 optReg held", optReg, optSeen);
    chk("R9 wrpReg held", {16'h0, wrpReg}, {16'h0, wrpSeen});
    chk("R1 no second done", {31'h0, loadDone}, 32'h0);
  endtask

  task automatic checkLoaded(input string tag, input logic [95:0] img);
    logic [15:0] p [6];
    logic [1:0]  lvl;
    logic        err;
    for (int k = 0; k < 6; k++) p[k] = img[16*k +: 16];
    err = 1'b0;
    for (int k = 0; k < 6; k++) err |= expBad(p[k]);
    lvl = (expByte(p[0]) == 8'hAA) ? 2'd0 : (expByte(p[0]) == 8'hCC) ? 2'd2 : 2'd1;
    chk({tag, " R3 optReg"}, optReg,
        {expByte(p[3]), expByte(p[2]), expByte(p[1]), expByte(p[0])});
    chk({tag, " R3 wrpReg"}, {16'h0, wrpReg}, {16'h0, expByte(p[5]), expByte(p[4])});
    chk({tag, " R6 rdpLevel"}, {30'h0, rdpLevel}, {30'h0, lvl});
    chk({tag, " R8 optErr"}, {31'h0, optErr}, {31'h0, err});
  endtask

  // R2 R3 R6: clean image, open level
  task automatic testClean();
    logic [95:0] img;
    img = {pr(8'h3C), pr(8'hF0), pr(8'h12), pr(8'h34), pr(8'h5E), pr(8'hAA)};
    runLoad(img);
    checkLoaded("clean", img);
    chk("R3 wrp byte1 explicit", {24'h0, wrpReg[15:8]}, 32'h3C);
    chk("R3 user data explicit", optReg, 32'h1234_5EAA);
  endtask

  // R6: sealed and other level codes
  task automatic testLevels();
    logic [95:0] img;
    img = {pr(8'h00), pr(8'h00), pr(8'h01), pr(8'h02), pr(8'h03), pr(8'hCC)};
    runLoad(img);
    chk("R6 level 2 for CC", {30'h0, rdpLevel}, 32'd2);
    img[15:0] = pr(8'h55);
    runLoad(img);
    chk("R6 level 1 for 55", {30'h0, rdpLevel}, 32'd1);
    checkLoaded("lvl55", img);
  endtask

  // R4: mismatch in user byte and in write-protect byte 1
  task automatic testMismatch();
    logic [95:0] img;
    img = {pr(8'h0F), pr(8'h00), pr(8'h77), pr(8'h66), pr(8'h21), pr(8'hAA)};
    img[31:24] = 8'h00;
    runLoad(img);
    chk("R4 user byte forced", {24'h0, optReg[15:8]}, 32'hFF);
    chk("R4 error flag", {31'h0, optErr}, 32'h1);
    checkLoaded("mis_user", img);
    img = {pr(8'h0F), pr(8'h00), pr(8'h77), pr(8'h66), pr(8'h21), pr(8'hAA)};
    img[95:88] = 8'h0F;
    runLoad(img);
    chk("R4 wrp byte1 forced", {24'h0, wrpReg[15:8]}, 32'hFF);
    chk("R4 wrp byte0 intact", {24'h0, wrpReg[7:0]}, 32'h00);
    checkLoaded("mis_wrp", img);
  endtask

  // R4 R6: corrupted read-protection byte falls to level 1
  task automatic testRdpCorrupt();
    logic [95:0] img;
    img = {pr(8'hFF), pr(8'hFF), pr(8'h01), pr(8'h02), pr(8'h03), 16'h00AA};
    runLoad(img);
    chk("R4 rdp byte forced", {24'h0, optReg[7:0]}, 32'hFF);
    chk("R6 corrupt rdp level 1", {30'h0, rdpLevel}, 32'd1);
    chk("R4 rdp err", {31'h0, optErr}, 32'h1);
  endtask

  // R5: erased word raises no error
  task automatic testErased();
    logic [95:0] img;
    img = {pr(8'h80), pr(8'h01), 32'hFFFF_FFFF, pr(8'h9A), pr(8'hAA)};
    runLoad(img);
    chk("R5 erased data bytes", {16'h0, optReg[31:16]}, 32'hFFFF);
    chk("R5 erased no error", {31'h0, optErr}, 32'h0);
    checkLoaded("erased", img);
  endtask

  // R8: error cleared by a new reset with a clean image; OR of several errors
  task automatic testReload();
    logic [95:0] img;
    img = {16'h1234, pr(8'h00), 16'h5555, pr(8'h00), pr(8'h00), pr(8'hAA)};
    runLoad(img);
    chk("R8 multi-error set", {31'h0, optErr}, 32'h1);
    checkLoaded("multi", img);
    img = {pr(8'h00), pr(8'h00), pr(8'h00), pr(8'h00), pr(8'h00), pr(8'hAA)};
    runLoad(img);
    chk("R8 cleared after reset", {31'h0, optErr}, 32'h0);
    chk("R3 all-protect wrp", {16'h0, wrpReg}, 32'h0);
  endtask

  initial begin
    testClean();
    testLevels();
    testMismatch();
    testRdpCorrupt();
    testErased();
    testReload();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule